// File: doc/BRIEF.md
# Sticky Sensor Status Flag Register

This block keeps the fault and status flags of a sensor that is accessed over SPI. It has two readable registers. The first is a plain status register. It shows whether analog test mode is active, whether the EEPROM checksum check has failed, and whether the last SPI frame was malformed. The second is a sticky interrupt status register. It latches output saturation, start-up self-test failure and continuous self-test failure.

The signal path and the self-test logic send one-cycle event pulses into the block. The SPI framing logic sends good-frame and bad-frame pulses, together with a register read strobe and an address. The block returns the registered read data. It also drives three summary bits that the shifter places into every outgoing SPI frame:
- a combined self-test bit,
- a saturation bit,
- a frame error bit.

Reading the interrupt status register is the acknowledgement. It clears the sticky flags, and the reader still sees the values that were latched before the clear.

Top module: `sensor_flag_regs`

## Requirements
- R1: After reset, every flag is zero, `rd_data_o` is 0x00 and all three frame summary bits are low.
- R2: A read strobe at address 0x02 loads `rd_data_o` on the next clock edge with {5'b0, atest_i, csum_err_i, frame-error flag}. Bit 2 is test mode, bit 1 is checksum error, bit 0 is frame error, and bits 7:3 are zero.
- R3: A `frame_bad_i` pulse sets the frame error flag. A later `frame_ok_i` pulse clears it. If both arrive in the same cycle, the flag is set. `frm_fe_o` follows the flag one cycle after the pulse.
- R4: While `csum_err_i` is high, `frm_st_o` is high in the same cycle, whatever the self-test flags hold.
- R5: A read at address 0x16 returns the interrupt flags at fixed positions: bit 7 saturation, bit 5 start-up self-test failure, bit 4 continuous self-test failure. Bits 6 and 3:0 read zero.
- R6: An event pulse on `sat_evt_i`, `sts_fail_i` or `stc_fail_i` sets its flag on the next edge. The flag stays set for any number of cycles until a read of 0x16.
- R7: A read of 0x16 returns the flags as they were before the read, and clears all three flags on the same edge.
- R8: An event pulse in the same cycle as a clearing read leaves that flag set after the read. The data returned by that read does not include the new event.
- R9: `frm_sat_o` equals the saturation flag. `frm_st_o` is high when either self-test flag or the checksum error is set.
- R10: A read of 0x02 or of any other address clears no flag. Any address other than 0x02 and 0x16 reads as 0x00.
- R11: `rd_data_o` changes only on a clock edge where `rd_en_i` was high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| atest_i | input | 1 | Analog test mode active (level) |
| csum_err_i | input | 1 | EEPROM checksum error (level) |
| sat_evt_i | input | 1 | Over-range event pulse from any axis |
| sts_fail_i | input | 1 | Start-up self-test failure pulse |
| stc_fail_i | input | 1 | Continuous self-test failure pulse |
| frame_ok_i | input | 1 | Correct SPI frame received |
| frame_bad_i | input | 1 | Malformed SPI frame received |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 8 | Registered read data |
| frm_st_o | output | 1 | Self-test summary bit for the SPI frame |
| frm_sat_o | output | 1 | Saturation summary bit for the SPI frame |
| frm_fe_o | output | 1 | Frame error summary bit for the SPI frame |

## Verification
Timing of each result, counted from the clock edge where the bench drives a stimulus:
- Read data, the latched interrupt flags and the frame error flag are due one edge after the strobe or pulse. They are therefore visible at the falling edge that follows that rising edge.
- `frm_st_o` reacts to `csum_err_i` in the same cycle, with no register on the path.

The bench drives inputs at a falling edge. It advances its reference model right after the next rising edge, using the same input values the design sampled. It then compares every output at the following falling edge. This places each comparison exactly where the latency above says the value becomes valid, and never at an edge.

// File: rtl/sensor_flag_regs.sv
module sensor_flag_regs #(
  parameter int            AW        = 8,
  parameter logic [AW-1:0] STAT_ADDR = 8'h02,
  parameter logic [AW-1:0] INT_ADDR  = 8'h16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          atest_i,
  input  logic          csum_err_i,
  input  logic          sat_evt_i,
  input  logic          sts_fail_i,
  input  logic          stc_fail_i,
  input  logic          frame_ok_i,
  input  logic          frame_bad_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic          frm_st_o,
  output logic          frm_sat_o,
  output logic          frm_fe_o
);

  logic       fe_q, sat_q, sts_q, stc_q;
  logic [7:0] rd_q;
  logic [7:0] rd_mux;
  logic       int_ack;

  assign int_ack = rd_en_i && (rd_addr_i == INT_ADDR);

  always_comb begin
    rd_mux = 8'h00;
    if (rd_addr_i == STAT_ADDR)
      rd_mux = {5'b0, atest_i, csum_err_i, fe_q};
    else if (rd_addr_i == INT_ADDR)
      rd_mux = {sat_q, 1'b0, sts_q, stc_q, 4'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fe_q  <= 1'b0;
      sat_q <= 1'b0;
      sts_q <= 1'b0;
      stc_q <= 1'b0;
      rd_q  <= 8'h00;
    end else begin
      if (frame_bad_i)     fe_q <= 1'b1;
      else if (frame_ok_i) fe_q <= 1'b0;
      sat_q <= sat_evt_i  | (sat_q & ~int_ack);
      sts_q <= sts_fail_i | (sts_q & ~int_ack);
      stc_q <= stc_fail_i | (stc_q & ~int_ack);
      if (rd_en_i) rd_q <= rd_mux;
    end
  end

  assign rd_data_o = rd_q;
  assign frm_st_o  = csum_err_i | sts_q | stc_q;
  assign frm_sat_o = sat_q;
  assign frm_fe_o  = fe_q;

  // R6
  sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_sat_o && !int_ack) |=> frm_sat_o);

  // R7
  sat_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !sat_evt_i) |=> !frm_sat_o);

  // R8
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_fail_i || stc_fail_i) |=> frm_st_o);

  // R3
  fe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad_i |=> frm_fe_o);

  // R3
  fe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok_i && !frame_bad_i) |=> !frm_fe_o);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));

  // R2
  stat_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_addr_i == STAT_ADDR) |=> (rd_data_o[7:3] == 5'b0));

  // R5
  int_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_addr_i == INT_ADDR) |=> (rd_data_o[6] == 1'b0 && rd_data_o[3:0] == 4'b0));

endmodule

// File: tb/sensor_flag_regs_bench.sv
`timescale 1ns/1ps
module sensor_flag_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       atest = 1'b0, csum = 1'b0, sat_e = 1'b0, sts_e = 1'b0, stc_e = 1'b0;
  logic       f_ok = 1'b0, f_bad = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] rd_data;
  logic       st, sat, fe;

  int compared = 0, mismatched = 0;
  bit done = 0;

  int m_fe = 0, m_sat = 0, m_sts = 0, m_stc = 0, m_rd = 0;
  int last_addr = 0;

  always #2.5 clk = ~clk;

  sensor_flag_regs u_sensor_flag_regs (
    .clk(clk), .rst_n(rst_n), .atest_i(atest), .csum_err_i(csum),
    .sat_evt_i(sat_e), .sts_fail_i(sts_e), .stc_fail_i(stc_e),
    .frame_ok_i(f_ok), .frame_bad_i(f_bad), .rd_en_i(rd_en), .rd_addr_i(addr),
    .rd_data_o(rd_data), .frm_st_o(st), .frm_sat_o(sat), .frm_fe_o(fe));

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (rd_en) begin
      last_addr = addr;
      if (addr == 8'h02)      m_rd = atest * 4 + csum * 2 + m_fe;
      else if (addr == 8'h16) m_rd = m_sat * 128 + m_sts * 32 + m_stc * 16;
      else                    m_rd = 0;
      if (addr == 8'h16) begin m_sat = 0; m_sts = 0; m_stc = 0; end
    end
    if (sat_e) m_sat = 1;
    if (sts_e) m_sts = 1;
    if (stc_e) m_stc = 1;
    if (f_bad) m_fe = 1; else if (f_ok) m_fe = 0;
  endtask

  task automatic compare_all();
    string rtag;
    if (last_addr == 8'h02) rtag = "R2";
    else if (last_addr == 8'h16) rtag = "R7";
    else rtag = "R10";
    check(rtag, rd_data, m_rd);
    check("R3", fe, m_fe);
    check("R9", sat, m_sat);
    check("R4", st, (csum || m_sts || m_stc) ? 1 : 0);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    sat_e = 0; sts_e = 0; stc_e = 0; f_ok = 0; f_bad = 0; rd_en = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    rd_en = 1; addr = a;
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", rd_data, 0); check("R1", st, 0); check("R1", sat, 0); check("R1", fe, 0);

    // R6 sticky saturation
    sat_e = 1; tick();
    repeat (4) tick();
    check("R6", sat, 1);
    // R5 layout and R7 clear
    rd(8'h16);
    check("R5", rd_data, 8'h80);
    check("R7", sat, 0);

    sts_e = 1; tick(); stc_e = 1; tick();
    check("R9", st, 1);
    rd(8'h16);
    check("R5", rd_data, 8'h30);
    check("R7", st, 0);

    // R8 event on the clearing read
    sat_e = 1; rd(8'h16);
    check("R8", rd_data, 8'h00);
    check("R8", sat, 1);
    rd(8'h16);
    check("R8", rd_data, 8'h80);

    // R4 checksum forces ST, same cycle
    csum = 1; #0.1;
    check("R4", st, 1);
    atest = 1;
    rd(8'h02);
    check("R2", rd_data, 8'h06);
    csum = 0; atest = 0;

    // R3 frame error set, clear, simultaneous
    f_bad = 1; tick(); check("R3", fe, 1);
    rd(8'h02); check("R2", rd_data, 8'h01);
    f_ok = 1; tick(); check("R3", fe, 0);
    f_ok = 1; f_bad = 1; tick(); check("R3", fe, 1);

    // R10 non-clearing reads
    sts_e = 1; sat_e = 1; tick();
    rd(8'h02); check("R10", sat, 1); check("R10", st, 1);
    rd(8'h33); check("R10", rd_data, 0); check("R10", sat, 1);

    // R11 hold without strobe
    addr = 8'h16; repeat (3) tick();
    check("R11", rd_data, 0);
    check("R11", sat, 1);

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      sat_e = (r % 13) == 0; sts_e = (r % 17) == 0; stc_e = (r % 19) == 0;
      f_bad = ($urandom % 8) == 0; f_ok = ($urandom % 3) == 0;
      atest = ($urandom % 5) == 0; csum = ($urandom % 6) == 0;
      rd_en = ($urandom % 4) == 0;
      case ($urandom % 4)
        0: addr = 8'h02;
        1, 2: addr = 8'h16;
        default: addr = 8'($urandom);
      endcase
      tick();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      mismatched++;
      $display("FAIL R11 watchdog: actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule